// File: doc/BRIEF.md
# Paged Register Access Controller

This block lets a host reach a 16-bit register space on a device whose transaction port carries only an 8-bit register address. The upper address byte is a bank number. The device latches that bank when it is written to a dedicated page-select location. The lower byte then picks a register inside the current bank. The controller remembers which bank was last programmed successfully and sends the page-select write only when a request moves to another bank.

The host issues one request at a time through a valid/ready port. A request carries an operation code, a 16-bit address, write data and a bit mask. Three operations are supported: read, write, and a masked set that reads the register and writes back the merged value. The controller sequences the needed device transactions through a request/acknowledge port that returns read data and an error flag. It finishes every request with a one-cycle response that carries data and an error indication.

Top module: `paged_reg_access`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, bus_req is 0 and rsp_valid is 0.
- R2: After reset no bank is known. The first request always starts with a write of the bank byte (address bits 15:8) to device address 0xFF.
- R3: A request to the same bank as the last successful page write causes no page write. Its transaction uses the offset (address bits 7:0) directly.
- R4: A request to a different bank causes exactly one page write, to 0xFF, before its register transaction.
- R5: A read (op 2'b00) returns the device's read data on rsp_rdata with rsp_err 0.
- R6: A write (op 2'b01) writes req_wdata to the offset of the addressed register.
- R7: A masked set (op 2'b10) reads the register and then writes (old & ~mask) | (data & mask). Its response returns the old value.
- R8: If a page write fails, the request ends with rsp_err 1 and no register transaction, and the remembered bank stays unchanged.
- R9: If the read phase of a masked set fails, the request ends with rsp_err 1 and no write is issued.
- R10: An error on the register transaction itself is reported with rsp_err 1 and leaves the remembered bank valid.
- R11: While bus_req is high and bus_ack has not arrived, bus_we, bus_addr and bus_wdata stay unchanged.
- R12: Op code 2'b11 is answered with rsp_err 1 in the cycle after acceptance, with no device transaction.
- R13: rsp_valid lasts one cycle, and req_ready returns in the next cycle. With a device that acknowledges one cycle after a request, the response follows acceptance by two cycles per device transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_op | input | 2 | 00 read, 01 write, 10 masked set, 11 reserved |
| req_addr | input | 16 | Bank in bits 15:8, offset in bits 7:0 |
| req_wdata | input | 8 | Write or set data |
| req_mask | input | 8 | Set mask, 1 selects the new bit |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 8 | Read data, or old value for a set |
| rsp_err | output | 1 | Request failed |
| bus_req | output | 1 | Device transaction request, held until acknowledge |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Device register address |
| bus_wdata | output | 8 | Device write data |
| bus_ack | input | 1 | Device transaction done |
| bus_rdata | input | 8 | Device read data, valid with bus_ack |
| bus_err | input | 1 | Device transaction failed, valid with bus_ack |

## Verification
The bench device model raises its acknowledge in the cycle after it sees a request. Each device transaction therefore costs two cycles. A response is due 0, 2, 4 or 6 cycles after the acceptance edge for a reserved op, a cached read or write, a read or write with a bank switch or a cached set, and a set with a bank switch. Every scenario counts the clock edges between acceptance and the first falling-edge sample of rsp_valid and compares that count with the expected figure. Data, error and page-write counts are sampled at the same point. A monitor compares the bus fields in the waiting cycle with those in the acknowledge cycle of every transaction.

// File: rtl/paged_reg_pkg.sv
package paged_reg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PAGE  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESP  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] query_bank,
  output logic              hit,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  output logic              known,
  output logic [BANK_W-1:0] bank
);
  logic              known_q, known_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    known_d = known_q;
    bank_d  = bank_q;
    if (upd_en) begin
      known_d = 1'b1;
      bank_d  = upd_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q <= 1'b0;
      bank_q  <= '0;
    end else begin
      known_q <= known_d;
      bank_q  <= bank_d;
    end
  end

  assign hit   = known_q && (bank_q == query_bank);
  assign known = known_q;
  assign bank  = bank_q;

  // R2: the marker only leaves the invalid state through an update
  assert_known_needs_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(known_q) |-> $past(upd_en));
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] merged
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = mask[i] ? new_val[i] : old_val[i];
  end
endmodule

// File: rtl/access_seq.sv
module access_seq
  import paged_reg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] PAGE_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  input  logic              bank_hit,
  output logic              cache_upd,
  output logic [ADDR_W-DATA_W-1:0] cache_bank,
  output logic [DATA_W-1:0] old_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] mask_q,
  input  logic [DATA_W-1:0] merged_in,
  output logic              bus_req,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int BANK_W = ADDR_W - DATA_W;

  seq_st_e           st_q, st_d;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ld_req, ld_old, ld_rsp;
  logic              rsp_err_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  // next state
  always_comb begin
    st_d        = st_q;
    ld_req      = 1'b0;
    ld_old      = 1'b0;
    ld_rsp      = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_rdata_d = '0;
    cache_upd   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          if (req_op == OP_RSVD) begin
            st_d      = ST_RESP;
            ld_rsp    = 1'b1;
            rsp_err_d = 1'b1;
          end else if (!bank_hit) begin
            st_d = ST_PAGE;
          end else if (req_op == OP_WRITE) begin
            st_d = ST_WRITE;
          end else begin
            st_d = ST_READ;
          end
        end
      end
      ST_PAGE: begin
        if (bus_ack) begin
          if (bus_err) begin
            st_d      = ST_RESP;
            ld_rsp    = 1'b1;
            rsp_err_d = 1'b1;
          end else begin
            cache_upd = 1'b1;
            st_d      = (op_q == OP_WRITE) ? ST_WRITE : ST_READ;
          end
        end
      end
      ST_READ: begin
        if (bus_ack) begin
          if (bus_err) begin
            st_d      = ST_RESP;
            ld_rsp    = 1'b1;
            rsp_err_d = 1'b1;
          end else if (op_q == OP_SET) begin
            ld_old = 1'b1;
            st_d   = ST_WRITE;
          end else begin
            st_d        = ST_RESP;
            ld_rsp      = 1'b1;
            rsp_rdata_d = bus_rdata;
          end
        end
      end
      ST_WRITE: begin
        if (bus_ack) begin
          st_d        = ST_RESP;
          ld_rsp      = 1'b1;
          rsp_err_d   = bus_err;
          rsp_rdata_d = (op_q == OP_SET) ? old_q : '0;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_rsp) begin
        rsp_err_q   <= rsp_err_d;
        rsp_rdata_q <= rsp_rdata_d;
      end
    end
  end

  // request data registers, enable only
  always_ff @(posedge clk) begin
    if (ld_req) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
    if (ld_old) begin
      old_q <= bus_rdata;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_rdata  = rsp_rdata_q;
  assign rsp_err    = rsp_err_q;
  assign cache_bank = addr_q[ADDR_W-1:DATA_W];
  assign bus_req    = (st_q == ST_PAGE) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign bus_we     = (st_q == ST_PAGE) || (st_q == ST_WRITE);
  assign bus_addr   = (st_q == ST_PAGE) ? PAGE_ADDR : addr_q[DATA_W-1:0];
  assign bus_wdata  = (st_q == ST_PAGE) ? DATA_W'(addr_q[ADDR_W-1:DATA_W]) :
                      (op_q == OP_SET)  ? merged_in : wdata_q;

  initial begin
    assert (BANK_W <= DATA_W);
  end

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_no_write_after_rd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack && bus_err) |=> !bus_req);

  assert_rsvd_no_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |=> (!bus_req && rsp_valid && rsp_err));

  assert_page_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == PAGE_ADDR && st_q == ST_PAGE && bus_ack && bus_err)
      |=> (rsp_valid && rsp_err));
endmodule

// File: rtl/paged_reg_access.sv
module paged_reg_access #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] PAGE_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              bus_req,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  localparam int BANK_W = ADDR_W - DATA_W;

  logic              hit, known, upd;
  logic [BANK_W-1:0] upd_bank, cur_bank;
  logic [DATA_W-1:0] old_v, new_v, msk_v, merged_v;

  bank_tracker #(.BANK_W(BANK_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .query_bank (req_addr[ADDR_W-1:DATA_W]),
    .hit        (hit),
    .upd_en     (upd),
    .upd_bank   (upd_bank),
    .known      (known),
    .bank       (cur_bank)
  );

  rmw_merge #(.DATA_W(DATA_W)) u_mrg (
    .old_val (old_v),
    .new_val (new_v),
    .mask    (msk_v),
    .merged  (merged_v)
  );

  access_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_ADDR(PAGE_ADDR)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .bank_hit   (hit),
    .cache_upd  (upd),
    .cache_bank (upd_bank),
    .old_q      (old_v),
    .wdata_q    (new_v),
    .mask_q     (msk_v),
    .merged_in  (merged_v),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err)
  );

  // R2: with no bank known, any device transaction must be the page write
  assert_first_is_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !known) |-> (bus_we && bus_addr == PAGE_ADDR));

  // R8: the remembered bank moves only after an acknowledged, error-free page write
  assert_bank_change_on_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_bank) |-> $past(bus_req && bus_ack && !bus_err && bus_we && bus_addr == PAGE_ADDR));
endmodule

// File: tb/sim_paged_reg_access.sv
module sim_paged_reg_access;
  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_op;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, req_mask;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       rsp_err;
  logic       bus_req, bus_we;
  logic [7:0] bus_addr, bus_wdata;
  logic       bus_ack;
  logic [7:0] bus_rdata;
  logic       bus_err;

  int errors = 0;
  int checks = 0;

  paged_reg_access u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- device model ----------------
  logic [7:0] mem [0:1023];
  logic [7:0] tgt_page;
  int page_wr_cnt, rd_cnt, wr_cnt, txn_cnt;
  logic inj_page_err, inj_rd_err, inj_wr_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack   <= 1'b1;
      bus_rdata <= 8'h00;
      txn_cnt   <= txn_cnt + 1;
      if (bus_we && bus_addr == 8'hFF) begin
        bus_err <= inj_page_err;
        if (!inj_page_err) begin
          tgt_page    <= bus_wdata;
          page_wr_cnt <= page_wr_cnt + 1;
        end
      end else if (bus_we) begin
        bus_err <= inj_wr_err;
        if (!inj_wr_err) begin
          mem[{tgt_page[1:0], bus_addr}] <= bus_wdata;
          wr_cnt <= wr_cnt + 1;
        end
      end else begin
        bus_err <= inj_rd_err;
        rd_cnt  <= rd_cnt + 1;
        if (!inj_rd_err) bus_rdata <= mem[{tgt_page[1:0], bus_addr}];
      end
    end else begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
    end
  end

  function automatic logic [7:0] init_val(int idx);
    return idx[7:0] ^ 8'h5A ^ {6'd0, idx[9:8]};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R11 monitor: fields in the waiting cycle equal those in the acknowledge cycle
  logic       hold_v;
  logic [16:0] hold_snap;
  always @(negedge clk) begin
    if (!rst_n) hold_v <= 1'b0;
    else if (bus_req && !bus_ack) begin
      hold_v    <= 1'b1;
      hold_snap <= {bus_we, bus_addr, bus_wdata};
    end else if (bus_req && bus_ack && hold_v) begin
      hold_v <= 1'b0;
      check("R11", {15'd0, bus_we, bus_addr, bus_wdata}, {15'd0, hold_snap}, "bus fields held");
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [15:0] addr,
                       input logic [7:0] wd, input logic [7:0] mk,
                       output logic [7:0] rd, output logic er, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 64) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    @(posedge clk);
    @(negedge clk);
    check("R13", {31'd0, rsp_valid}, 0, "rsp_valid one cycle");
    check("R13", {31'd0, req_ready}, 1, "ready after response");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {31'd0, req_ready}, 1, "ready in reset");
    check("R1", {31'd0, bus_req}, 0, "bus_req in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, rsp_valid, bus_req}, 0, "idle after reset");
    check("R1", {31'd0, req_ready}, 1, "ready after reset");
  endtask

  task automatic t_first_read();
    logic [7:0] rd; logic er; int lat; int pw;
    pw = page_wr_cnt;
    do_op(2'b00, 16'h0312, 8'h00, 8'h00, rd, er, lat);
    check("R2", page_wr_cnt - pw, 1, "page write on first access");
    check("R2", tgt_page, 8'h03, "bank byte written");
    check("R5", rd, init_val({2'd3, 8'h12}), "read data");
    check("R5", er, 0, "read err");
    check("R13", lat, 4, "latency page+read");
  endtask

  task automatic t_same_bank();
    logic [7:0] rd; logic er; int lat; int pw;
    pw = page_wr_cnt;
    do_op(2'b00, 16'h0340, 8'h00, 8'h00, rd, er, lat);
    check("R3", page_wr_cnt - pw, 0, "no page write on same bank");
    check("R3", lat, 2, "latency cached read");
    check("R5", rd, init_val({2'd3, 8'h40}), "read data cached");
  endtask

  task automatic t_write_new_bank();
    logic [7:0] rd; logic er; int lat; int pw, wc;
    pw = page_wr_cnt; wc = wr_cnt;
    do_op(2'b01, 16'h0120, 8'hA5, 8'h00, rd, er, lat);
    check("R4", page_wr_cnt - pw, 1, "one page write on bank change");
    check("R4", lat, 4, "latency page+write");
    check("R6", mem[{2'd1, 8'h20}], 8'hA5, "written value");
    check("R6", wr_cnt - wc, 1, "one register write");
    check("R6", er, 0, "write err");
  endtask

  task automatic t_set_cached();
    logic [7:0] rd; logic er; int lat; int pw;
    pw = page_wr_cnt;
    // (A5 & ~0F) | (3C & 0F) = AC
    do_op(2'b10, 16'h0120, 8'h3C, 8'h0F, rd, er, lat);
    check("R7", mem[{2'd1, 8'h20}], 8'hAC, "merged value");
    check("R7", rd, 8'hA5, "old value returned");
    check("R7", lat, 4, "latency read+write");
    check("R3", page_wr_cnt - pw, 0, "set on cached bank");
  endtask

  task automatic t_set_new_bank();
    logic [7:0] rd; logic er; int lat; logic [7:0] old;
    old = init_val({2'd2, 8'h05});
    do_op(2'b10, 16'h0205, 8'hFF, 8'h81, rd, er, lat);
    check("R7", mem[{2'd2, 8'h05}], (old & 8'h7E) | 8'h81, "merged value bank 2");
    check("R4", lat, 6, "latency page+read+write");
    check("R4", tgt_page, 8'h02, "page switched");
  endtask

  task automatic t_page_err();
    logic [7:0] rd; logic er; int lat; int pw, rc;
    pw = page_wr_cnt; rc = rd_cnt;
    inj_page_err = 1'b1;
    do_op(2'b00, 16'h0310, 8'h00, 8'h00, rd, er, lat);
    inj_page_err = 1'b0;
    check("R8", er, 1, "page error reported");
    check("R8", lat, 2, "aborted after page write");
    check("R8", rd_cnt - rc, 0, "no register access");
    // remembered bank must still be 2
    do_op(2'b00, 16'h0206, 8'h00, 8'h00, rd, er, lat);
    check("R8", page_wr_cnt - pw, 0, "bank kept after failed page write");
    check("R8", lat, 2, "cached access after failure");
    check("R5", rd, init_val({2'd2, 8'h06}), "read after failure");
    do_op(2'b00, 16'h0310, 8'h00, 8'h00, rd, er, lat);
    check("R4", page_wr_cnt - pw, 1, "page write retried");
    check("R5", rd, init_val({2'd3, 8'h10}), "read bank 3");
  endtask

  task automatic t_set_rd_err();
    logic [7:0] rd; logic er; int lat; int wc;
    wc = wr_cnt;
    inj_rd_err = 1'b1;
    do_op(2'b10, 16'h0310, 8'hFF, 8'hFF, rd, er, lat);
    inj_rd_err = 1'b0;
    check("R9", er, 1, "set read error");
    check("R9", wr_cnt - wc, 0, "no write after read error");
    check("R9", lat, 2, "abort after read");
    check("R9", mem[{2'd3, 8'h10}], init_val({2'd3, 8'h10}), "register untouched");
  endtask

  task automatic t_wr_err();
    logic [7:0] rd; logic er; int lat; int pw;
    pw = page_wr_cnt;
    inj_wr_err = 1'b1;
    do_op(2'b01, 16'h0311, 8'h77, 8'h00, rd, er, lat);
    inj_wr_err = 1'b0;
    check("R10", er, 1, "write error reported");
    do_op(2'b00, 16'h0311, 8'h00, 8'h00, rd, er, lat);
    check("R10", page_wr_cnt - pw, 0, "bank still valid");
    check("R10", lat, 2, "cached after access error");
    check("R10", rd, init_val({2'd3, 8'h11}), "register unchanged");
  endtask

  task automatic t_rsvd();
    logic [7:0] rd; logic er; int lat; int tc;
    tc = txn_cnt;
    do_op(2'b11, 16'h0120, 8'h00, 8'h00, rd, er, lat);
    check("R12", er, 1, "reserved op error");
    check("R12", lat, 0, "immediate response");
    check("R12", txn_cnt - tc, 0, "no device transaction");
  endtask

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    tgt_page = 8'h00;
    page_wr_cnt = 0; rd_cnt = 0; wr_cnt = 0; txn_cnt = 0;
    inj_page_err = 1'b0; inj_rd_err = 1'b0; inj_wr_err = 1'b0;
    req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0; req_mask = '0;
    rst_n = 1'b0;
    t_reset();
    t_first_read();
    t_same_bank();
    t_write_new_bank();
    t_set_cached();
    t_set_new_bank();
    t_page_err();
    t_set_rd_err();
    t_wr_err();
    t_rsvd();
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule